// File: doc/BRIEF.md
# Serial Flash Boot Image Loader

After reset this block copies a firmware image from a serial flash on chip select zero into on-chip program memory, then releases the processor. It works over a single-lane SPI link in mode 0. It starts at a slow serial clock. At that rate it sets the write enable latch, writes a zero status byte so that any block protection is lifted, and polls the status register until the busy flag clears. It then switches to a fast serial clock and fetches the whole image with one fast-read frame, using the auto-incrementing address inside the flash.

The image begins with a four-byte little-endian length in bytes. The rest of the image follows that length field. The bytes are packed four at a time into 32-bit words and written through a synchronous RAM write port at word addresses that start at zero. When the last word has been written, a release output rises and then stays high. A length of zero, or a length larger than the program memory, stops the load with an error flag. In that case nothing is written and there is no release.

Top module: `flash_boot_loader`

## Requirements
- R1: During reset and in the first cycle after it, `spi_cs0_n` is high, `spi_sck` is low, and `mem_we`, `boot_done` and `boot_err` are low. `spi_cs1_n` is high at all times.
- R2: The serial link runs in mode 0. SCK idles low. MOSI carries bytes MSB first and changes only while SCK is low. MISO is sampled on the rising SCK edge.
- R3: The first frame holds the single byte 0x06. The second frame holds 0x01 followed by 0x00. Both frames run at the slow rate, where SCK stays high for SLOW_HALF clock cycles per bit.
- R4: After those two frames the loader sends two-byte frames that start with 0x05. It sends one per poll until a returned status byte has bit 0 equal to 0. No other frame comes between the polls.
- R5: Every frame up to and including the last poll runs at the slow rate. The fast-read frame runs with SCK high for FAST_HALF cycles per bit.
- R6: The fast-read frame starts with 0x0B. Three address bytes follow, MSB first, equal to IMG_BASE, and then one dummy byte. The header and all image bytes are read inside this same frame, which has 9 + length bytes for a valid image.
- R7: The first four bytes after the dummy byte form the image length in bytes, least significant byte first.
- R8: Image byte i goes to bits [8*(i mod 4)+7 : 8*(i mod 4)] of the word at address i/4. There are ceil(length/4) write strobes. The unused upper bytes of a final partial word are zero.
- R9: A length of 0, or a length greater than 4 * 2^MEM_AW, sets `boot_err`. The frame ends after the fourth header byte. No write strobe occurs and `boot_done` stays low.
- R10: `boot_done` is low during every write strobe. It rises in the cycle after the last strobe, stays high until reset, and no strobe follows it.
- R11: `spi_cs0_n` stays low for the whole of each frame. Between frames it stays high for at least CS_GAP clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs0_n | output | 1 | Active-low select of the boot flash |
| spi_cs1_n | output | 1 | Active-low second select, never asserted |
| mem_we | output | 1 | Program memory write strobe, one cycle per word |
| mem_addr | output | MEM_AW | Program memory word address |
| mem_wdata | output | 32 | Program memory write word |
| boot_done | output | 1 | Release to the processor, sticky |
| boot_err | output | 1 | Image length rejected, sticky |

## Verification
A model flash on the bench decodes the frames. It returns busy for a chosen number of polls and serves the image from a base address that is not zero, so a swapped address byte shows up as wrong data. Directed lengths of 4, 5 and 256 cover an exact single word, a zero-padded partial word and a completely full memory. Lengths of 0 and one byte over capacity cover the two ways to reject an image. Random lengths and busy counts mix lane positions with the number of polls. The bench also measures the SCK high time of each frame, which separates slow frames from fast ones. It measures the chip-select high time between frames as well, so that a rate switched at the wrong point or a gap that is too short shows up.

// File: rtl/fbl_pkg.sv
package fbl_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int LANE_W     = $clog2(WORD_BYTES);

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_FREAD = 8'h0B;

    // opcode, three address bytes, one dummy
    localparam int FREAD_LEAD = 5;

    typedef enum logic [3:0] {
        ST_GAP,
        ST_WREN,
        ST_WRSR_OP,
        ST_WRSR_DAT,
        ST_RDSR_OP,
        ST_RDSR_DAT,
        ST_RD_CMD,
        ST_HDR,
        ST_DATA,
        ST_FIN,
        ST_DONE,
        ST_ERR
    } boot_st_t;

    function automatic logic in_frame(boot_st_t s);
        return s inside {ST_WREN, ST_WRSR_OP, ST_WRSR_DAT, ST_RDSR_OP,
                         ST_RDSR_DAT, ST_RD_CMD, ST_HDR, ST_DATA};
    endfunction

    function automatic logic [7:0] cmd_byte(boot_st_t s, logic [2:0] idx,
                                            logic [23:0] base);
        logic [7:0] b;
        b = 8'h00;
        case (s)
            ST_WREN:    b = OP_WREN;
            ST_WRSR_OP: b = OP_WRSR;
            ST_RDSR_OP: b = OP_RDSR;
            ST_RD_CMD: begin
                case (idx)
                    3'd0:    b = OP_FREAD;
                    3'd1:    b = base[23:16];
                    3'd2:    b = base[15:8];
                    3'd3:    b = base[7:0];
                    default: b = 8'h00;
                endcase
            end
            default:    b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/fbl_spi_byte.sv
module fbl_spi_byte #(
    parameter int SLOW_HALF = 70,
    parameter int FAST_HALF = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fast,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);
    localparam int DW = $clog2(SLOW_HALF + 1);

    logic [DW-1:0] cnt, lim;
    logic [2:0]    bit_cnt;
    logic [7:0]    tx_sh, rx_sh;
    logic          act, sck_q;

    assign lim  = fast ? DW'(FAST_HALF - 1) : DW'(SLOW_HALF - 1);
    assign sck  = sck_q;
    assign mosi = tx_sh[7];
    assign busy = act;
    assign rx   = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            act     <= 1'b0;
            sck_q   <= 1'b0;
            cnt     <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (act) begin
                if (cnt == lim) begin
                    cnt <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        sck_q <= 1'b0;
                        if (bit_cnt == 3'd7) begin
                            act  <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (start) begin
                act     <= 1'b1;
                tx_sh   <= tx;
                cnt     <= '0;
                bit_cnt <= '0;
                sck_q   <= 1'b0;
            end
        end
    end

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !act |-> !sck_q); // R2
    AST_RATE_HELD_IN_BYTE: assert property (@(posedge clk) disable iff (rst)
        act && $past(act) |-> $stable(fast)); // R5

endmodule

// File: rtl/fbl_word_pack.sv
module fbl_word_pack
    import fbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [7:0]        in_byte,
    input  logic              in_last,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_word
);
    logic [LANE_W-1:0] lane;
    logic [WORD_W-1:0] acc, merged;

    always_comb begin
        merged = acc;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (lane == LANE_W'(i)) merged[8*i +: 8] = in_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane     <= '0;
            acc      <= '0;
            out_vld  <= 1'b0;
            out_word <= '0;
        end else begin
            out_vld <= 1'b0;
            if (in_vld) begin
                if (lane == LANE_W'(WORD_BYTES - 1) || in_last) begin
                    out_word <= merged;
                    out_vld  <= 1'b1;
                    acc      <= '0;
                    lane     <= '0;
                end else begin
                    acc  <= merged;
                    lane <= lane + 1'b1;
                end
            end
        end
    end

    AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> !out_vld); // R8

endmodule

// File: rtl/flash_boot_loader.sv
module flash_boot_loader
    import fbl_pkg::*;
#(
    parameter int          MEM_AW    = 12,
    parameter int          SLOW_HALF = 70,
    parameter int          FAST_HALF = 3,
    parameter int          CS_GAP    = 40,
    parameter logic [23:0] IMG_BASE  = 24'h000000
) (
    input  logic              clk,
    input  logic              rst,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs0_n,
    output logic              spi_cs1_n,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              boot_done,
    output logic              boot_err
);
    localparam int          LEN_W     = MEM_AW + LANE_W + 1;
    localparam logic [31:0] MAX_BYTES = 32'(WORD_BYTES) << MEM_AW;
    localparam int          GW        = $clog2(CS_GAP + 1);

    boot_st_t          state, nxt_q;
    logic [GW-1:0]     gap_cnt;
    logic              waiting, start_q, fast_q;
    logic [7:0]        tx_q;
    logic [2:0]        idx;
    logic [31:0]       len_q, hdr_len;
    logic [LEN_W-1:0]  remain;
    logic [MEM_AW-1:0] wr_ptr;
    logic              eng_busy, eng_done;
    logic [7:0]        eng_rx;
    logic              pk_vld, pk_in_vld, pk_last;

    fbl_spi_byte #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_shift (
        .clk(clk), .rst(rst), .fast(fast_q), .start(start_q), .tx(tx_q),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .busy(eng_busy),
        .done(eng_done), .rx(eng_rx)
    );

    assign pk_in_vld = (state == ST_DATA) && waiting && eng_done;
    assign pk_last   = (remain == LEN_W'(1));

    fbl_word_pack u_pack (
        .clk(clk), .rst(rst), .in_vld(pk_in_vld), .in_byte(eng_rx),
        .in_last(pk_last), .out_vld(pk_vld), .out_word(mem_wdata)
    );

    assign hdr_len   = {eng_rx, len_q[31:8]};
    assign spi_cs0_n = !in_frame(state);
    assign spi_cs1_n = 1'b1;
    assign mem_we    = pk_vld;
    assign mem_addr  = wr_ptr;
    assign boot_done = (state == ST_DONE);
    assign boot_err  = (state == ST_ERR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_GAP;
            nxt_q   <= ST_WREN;
            gap_cnt <= '0;
            waiting <= 1'b0;
            start_q <= 1'b0;
            tx_q    <= '0;
            fast_q  <= 1'b0;
            idx     <= '0;
            len_q   <= '0;
            remain  <= '0;
            wr_ptr  <= '0;
        end else begin
            start_q <= 1'b0;
            if (pk_vld) wr_ptr <= wr_ptr + 1'b1;
            case (state)
                ST_GAP: begin
                    if (gap_cnt == GW'(CS_GAP - 1)) begin
                        gap_cnt <= '0;
                        state   <= nxt_q;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                ST_FIN:  state <= ST_DONE;
                ST_DONE: state <= ST_DONE;
                ST_ERR:  state <= ST_ERR;
                default: begin
                    if (!waiting) begin
                        start_q <= 1'b1;
                        tx_q    <= cmd_byte(state, idx, IMG_BASE);
                        waiting <= 1'b1;
                    end else if (eng_done) begin
                        waiting <= 1'b0;
                        case (state)
                            ST_WREN: begin
                                state <= ST_GAP;
                                nxt_q <= ST_WRSR_OP;
                            end
                            ST_WRSR_OP: state <= ST_WRSR_DAT;
                            ST_WRSR_DAT: begin
                                state <= ST_GAP;
                                nxt_q <= ST_RDSR_OP;
                            end
                            ST_RDSR_OP: state <= ST_RDSR_DAT;
                            ST_RDSR_DAT: begin
                                state <= ST_GAP;
                                if (eng_rx[0]) begin
                                    nxt_q <= ST_RDSR_OP;
                                end else begin
                                    nxt_q  <= ST_RD_CMD;
                                    fast_q <= 1'b1;
                                    idx    <= '0;
                                end
                            end
                            ST_RD_CMD: begin
                                if (idx == 3'(FREAD_LEAD - 1)) begin
                                    idx   <= '0;
                                    state <= ST_HDR;
                                end else begin
                                    idx <= idx + 3'd1;
                                end
                            end
                            ST_HDR: begin
                                len_q <= hdr_len;
                                if (idx == 3'(WORD_BYTES - 1)) begin
                                    if (hdr_len == 32'd0 || hdr_len > MAX_BYTES) begin
                                        state <= ST_ERR;
                                    end else begin
                                        remain <= hdr_len[LEN_W-1:0];
                                        state  <= ST_DATA;
                                    end
                                end else begin
                                    idx <= idx + 3'd1;
                                end
                            end
                            ST_DATA: begin
                                remain <= remain - 1'b1;
                                if (pk_last) state <= ST_FIN;
                            end
                            default: state <= ST_ERR;
                        endcase
                    end
                end
            endcase
        end
    end

    AST_CS_LOW_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> !spi_cs0_n); // R11
    AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> boot_done); // R10
    AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(boot_done) |-> $past(mem_we)); // R10
    AST_WRITE_IN_IMAGE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((32'(mem_addr) << LANE_W) < len_q)); // R8
    AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        boot_err |-> !mem_we); // R9

endmodule

// File: tb/flash_boot_loader_test.sv
`timescale 1ns/1ps
module flash_boot_loader_test;

    localparam int          AW    = 6;
    localparam int          SLOW  = 12;
    localparam int          FAST  = 2;
    localparam int          GAP   = 8;
    localparam logic [23:0] BASE  = 24'h0A0100;
    localparam int          WORDS = 1 << AW;

    logic clk = 1'b0, rst = 1'b1;
    logic spi_sck, spi_mosi, spi_cs0_n, spi_cs1_n, mem_we, boot_done, boot_err;
    logic spi_miso = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;

    always #2.5 clk = ~clk;

    flash_boot_loader #(.MEM_AW(AW), .SLOW_HALF(SLOW), .FAST_HALF(FAST),
                        .CS_GAP(GAP), .IMG_BASE(BASE)) uut (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs0_n(spi_cs0_n), .spi_cs1_n(spi_cs1_n),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .boot_done(boot_done), .boot_err(boot_err)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model state
    logic [7:0]  img [512];
    logic [7:0]  status_reg;
    bit          wel, in_fr;
    int          polls_left, bc, k, nfr;
    logic [7:0]  rxsh, nxt, osh, op;
    logic [23:0] faddr;
    logic [7:0]  fr_b [32][8];
    int          fr_n [32];
    int          fr_hi [32];

    always @(negedge spi_cs0_n) begin
        bc = 0; k = 0; nxt = 8'h00; osh = 8'h00; spi_miso = 1'b0; in_fr = 1'b1;
    end

    always @(posedge spi_cs0_n) begin
        if (in_fr && nfr < 31) nfr++;
        in_fr = 1'b0;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs0_n) begin
            rxsh = {rxsh[6:0], spi_mosi};
            bc++;
            if (bc == 8) begin
                bc = 0;
                if (k < 8) fr_b[nfr][k] = rxsh;
                if (k == 0) op = rxsh;
                case (op)
                    8'h06: wel = 1'b1;
                    8'h01: if (k == 1 && wel) begin status_reg = rxsh; wel = 1'b0; end
                    8'h05: if (k == 0) begin
                        nxt = {status_reg[7:2], wel, polls_left > 0};
                        if (polls_left > 0) polls_left--;
                    end
                    8'h0B: begin
                        if (k >= 1 && k <= 3) faddr = {faddr[15:0], rxsh};
                        if (k >= 4) begin
                            nxt = img[int'(faddr - BASE) & 511];
                            faddr++;
                        end
                    end
                    default: ;
                endcase
                k++;
                fr_n[nfr] = k;
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs0_n) begin
            if (bc == 0) begin
                spi_miso = nxt[7]; osh = {nxt[6:0], 1'b0};
            end else begin
                spi_miso = osh[7]; osh = {osh[6:0], 1'b0};
            end
        end
    end

    // sampled monitors
    logic [31:0] pm [WORDS];
    int   nwr, wr_late, mosi_viol, hc, gc, min_gap;
    logic prev_sck, prev_mosi;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                pm[mem_addr] = mem_wdata;
                nwr++;
                if (boot_done) wr_late++;
            end
            if (spi_sck && prev_sck && spi_mosi !== prev_mosi) mosi_viol++;
            if (spi_sck) hc++;
            else begin
                if (hc > fr_hi[nfr]) fr_hi[nfr] = hc;
                hc = 0;
            end
            if (spi_cs0_n) gc++;
            else begin
                if (gc > 0 && gc < min_gap) min_gap = gc;
                gc = 0;
            end
        end
        prev_sck  = spi_sck;
        prev_mosi = spi_mosi;
    end

    function automatic logic [31:0] exp_word(int w, int len);
        logic [31:0] v = 0;
        for (int j = 0; j < 4; j++)
            if (4*w + j < len) v[8*j +: 8] = img[4 + 4*w + j];
        return v;
    endfunction

    task automatic run(input int len, input int busy);
        int t, rf, nw, bad;
        bit err_exp;
        rst = 1'b1;
        for (int i = 0; i < 512; i++) img[i] = 8'($urandom);
        img[0] = len[7:0]; img[1] = len[15:8]; img[2] = len[23:16]; img[3] = len[31:24];
        status_reg = 8'h1C; wel = 1'b0; polls_left = busy; nfr = 0; in_fr = 1'b0;
        for (int i = 0; i < 32; i++) begin fr_n[i] = 0; fr_hi[i] = 0; end
        for (int i = 0; i < WORDS; i++) pm[i] = 32'hDEAD_BEEF;
        nwr = 0; wr_late = 0; mosi_viol = 0; hc = 0; gc = 0; min_gap = 1 << 30;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(spi_cs0_n && spi_cs1_n && !spi_sck && !mem_we && !boot_done && !boot_err,
            "R1 reset outputs", {spi_cs0_n, spi_cs1_n, spi_sck, mem_we, boot_done, boot_err}, 6'b110000);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(spi_cs0_n && !spi_sck && !boot_done && !boot_err, "R1 first cycle",
            {spi_cs0_n, spi_sck, boot_done, boot_err}, 4'b1000);
        t = 0;
        while (!(boot_done || boot_err) && t < 40000) begin @(negedge clk); t++; end
        chk(t < 40000, "R10 boot finished", t, 40000);
        repeat (60) @(negedge clk);

        err_exp = (len == 0) || (len > 4 * WORDS);
        rf = 3 + busy;
        chk(fr_n[0] == 1 && fr_b[0][0] == 8'h06 && fr_hi[0] == SLOW, "R3 write enable frame",
            {fr_n[0], fr_b[0][0], fr_hi[0]}, {32'd1, 8'h06, SLOW});
        chk(fr_n[1] == 2 && fr_b[1][0] == 8'h01 && fr_b[1][1] == 8'h00 && fr_hi[1] == SLOW,
            "R3 write status frame", {fr_b[1][0], fr_b[1][1]}, 16'h0100);
        chk(status_reg == 8'h00, "R3 protection cleared", status_reg, 0);
        bad = 0;
        for (int f = 2; f < rf; f++)
            if (fr_n[f] != 2 || fr_b[f][0] != 8'h05 || fr_hi[f] != SLOW) bad++;
        chk(bad == 0 && nfr == rf + 1, "R4 status polls", nfr, rf + 1);
        chk(fr_hi[rf] == FAST, "R5 fast rate on read", fr_hi[rf], FAST);
        chk(fr_b[rf][0] == 8'h0B && fr_b[rf][1] == BASE[23:16] && fr_b[rf][2] == BASE[15:8]
            && fr_b[rf][3] == BASE[7:0], "R6 fast read command",
            {fr_b[rf][0], fr_b[rf][1], fr_b[rf][2], fr_b[rf][3]}, {8'h0B, BASE});
        chk(fr_n[rf] == (err_exp ? 9 : 9 + len), "R6 single read frame length", fr_n[rf],
            err_exp ? 9 : 9 + len);
        chk(min_gap >= GAP, "R11 deselect gap", min_gap, GAP);
        chk(mosi_viol == 0, "R2 MOSI stable while SCK high", mosi_viol, 0);
        if (err_exp) begin
            chk(boot_err && !boot_done && spi_cs0_n, "R9 rejected length",
                {boot_err, boot_done, spi_cs0_n}, 3'b101);
            chk(nwr == 0, "R9 no writes", nwr, 0);
        end else begin
            nw = (len + 3) / 4;
            chk(boot_done && !boot_err && spi_cs0_n, "R10 released", {boot_done, boot_err}, 2'b10);
            chk(nwr == nw, "R7 word count from header", nwr, nw);
            chk(wr_late == 0, "R10 no write after release", wr_late, 0);
            bad = 0;
            for (int w = 0; w < nw; w++)
                if (pm[w] !== exp_word(w, len)) begin
                    if (bad == 0) chk(0, "R8 word content", pm[w], exp_word(w, len));
                    bad++;
                end
            chk(bad == 0, "R8 all words", bad, 0);
        end
    endtask

    initial begin
        int s;
        s = $urandom(32'd4711);
        run(5, 2);
        run(4, 0);
        run(256, 1);
        run(257, 0);
        run(0, 1);
        for (int r = 0; r < 4; r++) run(1 + $urandom_range(255, 0), $urandom_range(3, 0));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule